// File: doc/BRIEF.md
# PHY Initialization Timing Sequencer

This block runs the power-up and re-synchronisation sequence of a storage-interface PHY in hardware. Software writes a 32-bit timing control word. If the top bit is set, the block latches four 4-bit phase durations from the low half-word and steps through four phases in bus-clock cycles. First it drives a sync-enable pulse. Then it waits an idle gap, drives a sync-reset pulse, and holds for a settling time plus a fixed allowance of extra cycles. At the end it clears the start bit by itself and raises a one-cycle done pulse.

Software must request a fresh initialization every time the card clock frequency changes, every time the card clock is stopped and restarted, and every time the timing or function settings change. It polls the start bit, or waits for the done pulse, to learn when the PHY is usable. The mode bits in the same word are stored and read back unchanged across a run. These are a bypass (slow) mode on bit 29 and an SDIO mode on bit 28.

Top module: `phyinit_seq`

## Requirements
- R1: While reset is held and after it is released, rd_data reads 0, ready is 1, and sync_en, sync_rst and done are 0.
- R2: A write with bit 31 clear while ready is 1 stores all 32 bits so that they read back on rd_data the next cycle. No sequence starts: ready stays 1 and sync_en and sync_rst stay 0.
- R3: A write with bit 31 set while ready is 1 starts a sequence. From the next cycle until the sequence ends, ready is 0 and rd_data bit 31 reads 1.
- R4: Field positions are: bits [11:8] give the sync-enable length, bits [7:4] give the gap length, and bits [3:0] give the sync-reset length. From the cycle after the start write, sync_en is high for the sync-enable length in cycles. Then both outputs are low for the gap length. Then sync_rst is high for the sync-reset length. The two outputs are never high together.
- R5: After the sync-reset phase the block waits the value of bits [15:12] plus 8 cycles. Bit 31 therefore clears, and ready returns to 1, exactly (sum of the four fields + 8) cycles after the start write.
- R6: A field of value 0 removes its phase entirely and costs no cycle. An all-zero word gives a sequence of exactly 8 cycles.
- R7: Any write made while ready is 0 is dropped. The register contents do not change, and the running sequence is neither restarted nor lengthened.
- R8: done is high for exactly one cycle: the first cycle in which rd_data bit 31 reads 0 again after a sequence. ready is 1 in that cycle.
- R9: Bits [30:0] of the stored word, including the bypass-mode bit 29 and the SDIO-mode bit 28, are unchanged by a sequence. Only bit 31 is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all phase lengths count its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the timing control word |
| wr_data | input | 32 | Word to write; bit 31 requests an initialization |
| rd_data | output | 32 | Current timing control word |
| sync_en | output | 1 | Sync-enable pulse to the PHY |
| sync_rst | output | 1 | Sync-reset pulse to the PHY |
| ready | output | 1 | High when no sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The bench builds the block with its default parameters: 4-bit fields and an extra allowance of 4 bus cycles plus 4 interconnect cycles. With these values every field value from 0 to 15 can be reached. The all-ones word drives the phase counter to its largest load of 22 within its 5-bit width. The all-zero word exercises the shortest run, which consists of the fixed allowance alone. Mixed words with zero fields in different places exercise phase skipping in every position. Writes placed early and late inside a run exercise the rule that busy writes are dropped.

// File: rtl/phyinit_pkg.sv
// Package: shared phase encoding and field layout of the timing control word.
// Assumes the four duration fields are packed from bit 0 upward in the order
// sync-reset, gap, sync-enable, settle.
package phyinit_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_SYNC_EN  = 3'd1,
        PH_GAP      = 3'd2,
        PH_SYNC_RST = 3'd3,
        PH_SETTLE   = 3'd4
    } phase_e;

    localparam int NUM_FIELDS = 4;
    localparam int IDX_RST    = 0;
    localparam int IDX_GAP    = 1;
    localparam int IDX_EN     = 2;
    localparam int IDX_SETTLE = 3;

    localparam int POS_SDIO   = 28;
    localparam int POS_BYPASS = 29;

endpackage

// File: rtl/phyinit_cfg_reg.sv
// Module: holds the timing control word.
// Accepts writes only while the sequencer is idle and clears the start bit
// when the sequencer reports completion. Assumes finish is never raised
// while idle, so an accepted write and a completion never coincide.
module phyinit_cfg_reg #(
    parameter int DATA_W    = 32,
    parameter int START_POS = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idle,
    input  logic              finish,
    output logic [DATA_W-1:0] cfg_q,
    output logic              launch
);

    // Start request: only honoured while no sequence runs.
    assign launch = wr_en && idle && wr_data[START_POS];

    // Register update: idle writes load the word, completion clears bit 31.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && idle) begin
            cfg_q <= wr_data;
        end else if (finish) begin
            cfg_q[START_POS] <= 1'b0;
        end
    end

    assert_busy_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idle && !finish) |=> $stable(cfg_q));

    assert_start_held_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> cfg_q[START_POS]);

    assert_start_clear_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !cfg_q[START_POS]);

endmodule

// File: rtl/phyinit_phase_timer.sv
// Module: down-counter that times one phase.
// Loaded with (length - 1) when a phase begins. It reports expiry when it
// reaches zero and then holds at zero until it is loaded again.
module phyinit_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    assert_timer_holds_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

    assert_timer_loads_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/phyinit_phase_fsm.sv
// Module: phase sequencer.
// Snapshots the four duration fields at launch and walks the phases
// sync-enable, gap, sync-reset and settle, in that order. A phase whose
// length is zero is skipped in the same cycle. Settle always lasts its field
// plus EXTRA cycles, so it is never empty. Assumes launch is raised only
// while idle.
module phyinit_phase_fsm
    import phyinit_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int EXTRA   = 8,
    parameter int CNT_W   = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          launch,
    input  logic [NUM_FIELDS*FIELD_W-1:0] launch_cfg,
    input  logic                          expired,
    output logic                          tmr_load,
    output logic [CNT_W-1:0]              tmr_val,
    output logic                          idle,
    output logic                          finish,
    output logic                          sync_en,
    output logic                          sync_rst,
    output logic                          done_q
);

    logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_in;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_q;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_src;
    phase_e                             phase_q;
    phase_e                             from_ph;
    phase_e                             pick_ph;
    logic [CNT_W-1:0]                   pick_len;
    logic                               start_ok;
    logic                               step;

    // Unpack the duration fields from the incoming word.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_unpack
        assign fld_in[g] = launch_cfg[g*FIELD_W +: FIELD_W];
    end

    // Length of a phase in cycles for a given set of fields.
    function automatic logic [CNT_W-1:0] len_of(
        input phase_e p,
        input logic [NUM_FIELDS-1:0][FIELD_W-1:0] f
    );
        case (p)
            PH_SYNC_EN:  return CNT_W'(f[IDX_EN]);
            PH_GAP:      return CNT_W'(f[IDX_GAP]);
            PH_SYNC_RST: return CNT_W'(f[IDX_RST]);
            PH_SETTLE:   return CNT_W'(f[IDX_SETTLE]) + CNT_W'(EXTRA);
            default:     return '0;
        endcase
    endfunction

    assign idle     = (phase_q == PH_IDLE);
    assign start_ok = launch && idle;
    assign step     = !idle && expired;
    assign finish   = (phase_q == PH_SETTLE) && expired;
    assign fld_src  = start_ok ? fld_in : fld_q;
    assign from_ph  = start_ok ? PH_IDLE : phase_q;

    // Choose the first non-empty phase after the current one.
    always_comb begin
        pick_ph  = PH_SETTLE;
        pick_len = len_of(PH_SETTLE, fld_src);
        for (int i = 3; i >= 0; i--) begin
            if ((i >= int'(from_ph)) && (len_of(phase_e'(3'(i + 1)), fld_src) != '0)) begin
                pick_ph  = phase_e'(3'(i + 1));
                pick_len = len_of(phase_e'(3'(i + 1)), fld_src);
            end
        end
    end

    assign tmr_load = start_ok || (step && !finish);
    assign tmr_val  = pick_len - 1'b1;

    // Phase register: advance on launch or when the current phase expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (start_ok) begin
            phase_q <= pick_ph;
        end else if (finish) begin
            phase_q <= PH_IDLE;
        end else if (step) begin
            phase_q <= pick_ph;
        end
    end

    // Field snapshot taken at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else if (start_ok) begin
            fld_q <= fld_in;
        end
    end

    // Completion pulse, one cycle after the final settle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
        end
    end

    assign sync_en  = (phase_q == PH_SYNC_EN);
    assign sync_rst = (phase_q == PH_SYNC_RST);

    assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_en && sync_rst));

    assert_done_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!sync_en && !sync_rst));

    assert_launch_leaves_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> !idle);

    assert_settle_after_reset_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_rst) |-> (phase_q == PH_SETTLE));

    assert_done_after_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(phase_q) == PH_SETTLE) && idle);

endmodule

// File: rtl/phyinit_seq.sv
// Module: top of the PHY initialization sequencer.
// Connects the control-word register, the phase sequencer and the phase
// timer. Phase lengths are counted in bus clocks. The fixed allowance is
// BUS_EXTRA bus cycles plus XBAR_EXTRA interconnect cycles, both counted
// here on the bus clock.
module phyinit_seq #(
    parameter int DATA_W     = 32,
    parameter int FIELD_W    = 4,
    parameter int BUS_EXTRA  = 4,
    parameter int XBAR_EXTRA = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sync_en,
    output logic              sync_rst,
    output logic              ready,
    output logic              done
);
    import phyinit_pkg::*;

    localparam int EXTRA     = BUS_EXTRA + XBAR_EXTRA;
    localparam int CNT_W     = $clog2((1 << FIELD_W) + EXTRA);
    localparam int START_POS = DATA_W - 1;
    localparam int CFG_W     = NUM_FIELDS * FIELD_W;

    logic              launch;
    logic              idle;
    logic              finish;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              expired;
    logic [DATA_W-1:0] cfg_q;

    phyinit_cfg_reg #(
        .DATA_W    (DATA_W),
        .START_POS (START_POS)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .idle    (idle),
        .finish  (finish),
        .cfg_q   (cfg_q),
        .launch  (launch)
    );

    phyinit_phase_fsm #(
        .FIELD_W (FIELD_W),
        .EXTRA   (EXTRA),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_cfg (wr_data[CFG_W-1:0]),
        .expired    (expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .idle       (idle),
        .finish     (finish),
        .sync_en    (sync_en),
        .sync_rst   (sync_rst),
        .done_q     (done)
    );

    phyinit_phase_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    assign rd_data = cfg_q;
    assign ready   = idle;

    assert_done_clears_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_data[START_POS] && ready));

    assert_low_bits_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(rd_data[DATA_W-2:0]));

    assert_mode_bits_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable({rd_data[POS_BYPASS], rd_data[POS_SDIO]}));

endmodule

// File: tb/phyinit_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: a scoreboard. The driver tasks push one expected item per cycle
// into a queue; the monitor pops one item at every falling edge and compares
// it with the ports.
module phyinit_seq_tb_top;

    typedef struct packed {
        logic        en;
        logic        rst;
        logic        rdy;
        logic        dn;
        logic [31:0] rd;
        logic [3:0]  rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        sync_en, sync_rst, ready, done;

    exp_t        exp_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] shadow = '0;

    always #2.5 clk = ~clk;

    phyinit_seq dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .sync_en  (sync_en),
        .sync_rst (sync_rst),
        .ready    (ready),
        .done     (done)
    );

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Monitor: compare each cycle with the next expected item.
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if ({sync_en, sync_rst, ready, done, rd_data} !== {e.en, e.rst, e.rdy, e.dn, e.rd}) begin
                n_fail++;
                $display("FAIL %s en/rst/ready/done/rd actual=%b%b%b%b %h expected=%b%b%b%b %h",
                         tag(e.rq), sync_en, sync_rst, ready, done, rd_data,
                         e.en, e.rst, e.rdy, e.dn, e.rd);
            end
        end
    end

    task automatic push(input logic en, input logic rs, input logic rdy, input logic dn,
                        input logic [31:0] rd, input logic [3:0] rq);
        exp_t e;
        e.en = en; e.rst = rs; e.rdy = rdy; e.dn = dn; e.rd = rd; e.rq = rq;
        exp_q.push_back(e);
    endtask

    // Driver: idle write without the start bit (R2).
    task automatic write_idle(input logic [31:0] data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = data;
        push(0, 0, 1, 0, shadow, 4'd2);
        push(0, 0, 1, 0, data, 4'd2);
        push(0, 0, 1, 0, data, 4'd2);
        @(posedge clk); #1;
        wr_en = 1'b0;
        wait (exp_q.size() == 0);
        shadow = data;
    endtask

    // Driver: start a sequence, optionally write again at step intr_at.
    task automatic run_seq(input logic [31:0] cfg, input logic [3:0] rq,
                           input int intr_at, input logic [31:0] intr_data);
        int ne, ng, nr, nw, t;
        ne = int'(cfg[11:8]); ng = int'(cfg[7:4]);
        nr = int'(cfg[3:0]);  nw = int'(cfg[15:12]);
        t  = ne + ng + nr + nw + 8;
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = cfg;
        push(0, 0, 1, 0, shadow, rq);
        for (int i = 1; i <= t + 2; i++) begin
            push(i <= ne,
                 (i > ne + ng) && (i <= ne + ng + nr),
                 i > t,
                 i == t + 1,
                 (i <= t) ? cfg : (cfg & 32'h7FFF_FFFF),
                 (i == t + 1) ? 4'd8 : rq);
        end
        for (int i = 1; i <= t + 1; i++) begin
            @(posedge clk); #1;
            wr_en = (i == intr_at);
            if (i == intr_at) wr_data = intr_data;
        end
        wr_en = 1'b0;
        wait (exp_q.size() == 0);
        shadow = cfg & 32'h7FFF_FFFF;
        repeat (2) @(posedge clk);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=still running expected=sequence complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state, checked during and after reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if ({sync_en, sync_rst, ready, done, rd_data} !== {4'b0010, 32'h0}) begin
            n_fail++;
            $display("FAIL R1 during reset actual=%b%b%b%b %h expected=0010 00000000",
                     sync_en, sync_rst, ready, done, rd_data);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        push(0, 0, 1, 0, 32'h0, 4'd1);
        push(0, 0, 1, 0, 32'h0, 4'd1);
        wait (exp_q.size() == 0);

        write_idle(32'h3000_A5A5);                                // R2
        run_seq(32'h8000_1234, 4'd3, 0, 32'h0);                   // R3
        run_seq(32'h8000_3213, 4'd4, 0, 32'h0);                   // R4
        run_seq(32'h8000_FFFF, 4'd5, 0, 32'h0);                   // R5 longest run
        run_seq(32'h8000_0000, 4'd6, 0, 32'h0);                   // R6 all phases empty
        run_seq(32'h8000_0A05, 4'd6, 0, 32'h0);                   // R6 gap and settle field zero
        run_seq(32'h8000_5030, 4'd6, 0, 32'h0);                   // R6 both pulses skipped
        run_seq(32'h8000_4444, 4'd7, 3, 32'h8000_0001);           // R7 restart attempt
        run_seq(32'h8000_4444, 4'd7, 23, 32'h0000_0000);          // R7 late overwrite
        run_seq(32'hF5A6_2222, 4'd9, 0, 32'h0);                   // R9 mode bits kept
        write_idle(32'h1000_0000);                                // R2 second pattern

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule